// File: doc/BRIEF.md
# I2C Target with Register Pointer

This block is an I2C target that gives a bus host access to a bank of 64 eight-bit registers. Access goes through an 8-bit pointer register. The target answers to a 7-bit address. The upper four bits of that address are fixed at binary 1001, and the lower three come from strap inputs. SCL and SDA are sampled with the system clock. The block drives SDA only through an output enable: when the enable is 1, the pad pulls SDA low. Clock stretching, general-call addressing and 10-bit addressing are not supported.

To write, the host sends the address byte with R/W = 0. The next byte loads the pointer, and every byte after that is stored at the pointed register. A write that holds only the pointer byte just selects a register for a later read. To read, the host sends the address byte with R/W = 1. The target then shifts out the pointed register. The host ACKs each byte if it wants another one, and ends the read with a NACK and a stop.

Top module: `i2cRegTarget`

## Requirements
- R1: After reset, SDA is released (sdaOe = 0), the pointer is 0 and every register reads 0.
- R2: The target ACKs (drives sdaOe = 1 during the ninth clock) an address byte whose first seven bits are 1,0,0,1,addrStrap[2],addrStrap[1],addrStrap[0]. The eighth bit is R/W, with 1 meaning read.
- R3: The first byte after a write address is loaded into the pointer MSB first and is ACKed. A transaction that holds only this byte changes no register.
- R4: Each further byte in a write transaction is ACKed and stored into the register the pointer selects.
- R5: On a read, the selected register is driven MSB first, one bit per SCL clock. sdaOe = 1 means a 0 bit, and sdaOe never changes while SCL is high.
- R6: A read with no pointer write before it returns the register the pointer currently selects.
- R7: When the address does not match, no ACK is given, no later byte of that transaction is ACKed, and no register is written.
- R8: The pointer advances by one after each stored write byte, and after each read byte that the host ACKs (SDA = 0 on the ninth clock). It wraps from 3Fh to 00h.
- R9: Only pointer bits 5..0 index the register file; bits 7..6 are ignored.
- R10: A start or stop seen in any state restarts byte reception, so a transaction that is cut short or followed by a repeated start is handled correctly. After a host NACK, SDA stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the pad |
| addrStrap | input | 3 | Strapped low bits of the target address |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The bench runs several patterns against its own model:
- single-byte writes and reads, which separate the pointer byte from the data bytes;
- pointer-only writes followed by reads, and repeated reads with no new pointer, which show whether the pointer is kept;
- multi-byte writes and reads that start near 3Fh, which expose the wrap point and the rule that a read advances the pointer only when the host ACKs;
- a pointer with its upper bits set, which shows whether those bits leak into the register index;
- foreign addresses, an aborted address byte and a repeated start, which show whether stray bus activity ever disturbs the registers or the bit counting.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } ctrlStb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STRAP_W = 3,
  parameter logic [DATA_W-STRAP_W-2:0] ADDR_HI = 4'b1001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic               txBit,
  output ctrlStb_t           stb,
  output logic               rxBit,
  output logic               sdaOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  logic sclMeta, sclS, sclQ, sdaMeta, sdaS, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic ackPhase, rdMore, receiving, addrHit, byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclS, sclQ} <= 3'b111;
      {sdaMeta, sdaS, sdaQ} <= 3'b111;
    end else begin
      {sclMeta, sclS, sclQ} <= {scl, sclMeta, sclS};
      {sdaMeta, sdaS, sdaQ} <= {sdaIn, sdaMeta, sdaS};
    end
  end

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign rxBit    = sdaS;

  assign receiving = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
  assign addrHit   = rxByte[DATA_W-1:1] == {ADDR_HI, addrStrap};
  assign byteDone  = bitCnt == LAST_BIT;

  always_comb begin
    stb = '0;
    if (!startDet && !stopDet) begin
      if (receiving && sclRise && !byteDone) stb.shiftIn = 1'b1;
      if (sclFall && byteDone && !ackPhase) begin
        if (state == ST_PTR) stb.loadPtr = 1'b1;
        if (state == ST_WDATA) begin
          stb.writeReg = 1'b1;
          stb.incPtr   = 1'b1;
        end
      end
      if (state == ST_ADDR && sclFall && ackPhase && rxByte[0]) stb.loadTx = 1'b1;
      if (state == ST_RDATA && sclFall && !byteDone) stb.shiftTx = 1'b1;
      if (state == ST_RACK && sclRise && !sdaS) stb.incPtr = 1'b1;
      if (state == ST_RACK && sclFall && rdMore) stb.loadTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      rdMore   <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            if (!ackPhase) begin
              if (state == ST_ADDR && !addrHit) begin
                state  <= ST_IGNORE;
                bitCnt <= '0;
              end else begin
                ackPhase <= 1'b1;
              end
            end else begin
              ackPhase <= 1'b0;
              bitCnt   <= '0;
              if (state == ST_ADDR) state <= rxByte[0] ? ST_RDATA : ST_PTR;
              else state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            state  <= ST_RACK;
            bitCnt <= '0;
          end
        end
        ST_RACK: begin
          if (sclRise) rdMore <= ~sdaS;
          if (sclFall) state <= rdMore ? ST_RDATA : ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (receiving & ackPhase) | ((state == ST_RDATA) & ~txBit);

endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              rxBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic [DATA_W-1:0] ptrOut
);
  localparam int IDX_W = $clog2(REG_DEPTH);

  logic [DATA_W-1:0] regFile [REG_DEPTH];
  logic [DATA_W-1:0] ptr, txShift;
  logic [IDX_W-1:0]  idx;

  assign idx    = ptr[IDX_W-1:0];
  assign txBit  = txShift[DATA_W-1];
  assign ptrOut = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      ptr     <= '0;
      txShift <= '0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[DATA_W-2:0], rxBit};
      if (stb.loadPtr) ptr <= rxByte;
      else if (stb.incPtr) ptr <= (&idx) ? '0 : ptr + 1'b1;
      if (stb.loadTx) txShift <= regFile[idx];
      else if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  for (genvar g = 0; g < REG_DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (stb.writeReg && idx == IDX_W'(g)) regFile[g] <= rxByte;
    end
  end

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cRegPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_DEPTH = 64,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  output logic               sdaOe
);
  ctrlStb_t          stb;
  logic [DATA_W-1:0] rxByte, ptrQ;
  logic              rxBit, txBit;

  i2cRegCtrl #(.DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .rxBit(rxBit), .sdaOe(sdaOe)
  );

  i2cRegData #(.DATA_W(DATA_W), .REG_DEPTH(REG_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rxBit(rxBit),
    .rxByte(rxByte), .txBit(txBit), .ptrOut(ptrQ)
  );

endmodule

// File: rtl/i2cRegTarget_chk.sv
module i2cRegTarget_chk
  import i2cRegPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              sdaIn,
  input logic              sdaOe,
  input ctrlStb_t          stb,
  input logic [DATA_W-1:0] rxByte,
  input logic [DATA_W-1:0] ptrQ
);
  logic [2:0] highRun;
  logic sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= '0;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      highRun <= !scl ? 3'd0 : (highRun == 3'd7 ? highRun : highRun + 1'b1);
      sclQ    <= scl;
      sdaQ    <= sdaIn;
    end
  end

  a_r1_reset_release: assert property (@(posedge clk) !rstN |=> !sdaOe);

  a_r5_stable_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (highRun >= 3'd6) |-> $stable(sdaOe));

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ && scl && !sdaQ && sdaIn) |-> ##4 !sdaOe);

  a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadPtr |=> ptrQ == $past(rxByte));

  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPtr && !stb.loadPtr && (&ptrQ[IDX_W-1:0])) |=> ptrQ == '0);

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadPtr, stb.writeReg, stb.loadTx, stb.shiftTx}));

endmodule

bind i2cRegTarget i2cRegTarget_chk u_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .sdaOe(sdaOe),
  .stb(stb), .rxByte(rxByte), .ptrQ(ptrQ)
);

// File: tb/i2cRegTarget_bench.sv
`timescale 1ns/1ps
module i2cRegTarget_bench;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MY_ADDR = {4'b1001, STRAP};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic expOe = 1'b0;
  logic chkOn = 1'b0;
  logic lastBit;
  string curReq = "R1";
  int compared = 0;
  int mismatched = 0;
  int regsM [64];
  int ptrM = 0;

  always #5 clk = ~clk;
  assign sdaLine = sdaHost & ~sdaOe;

  i2cRegTarget u_i2cRegTarget (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine),
    .addrStrap(STRAP), .sdaOe(sdaOe)
  );

  // per-clock comparison of the drive enable against the model while SCL is high
  always @(negedge clk) begin
    if (chkOn) begin
      compared++;
      if (sdaOe !== expOe) begin
        mismatched++;
        $display("FAIL %s: sdaOe actual %0b expected %0b at %0t", curReq, sdaOe, expOe, $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nextPtr(input int p);
    return ((p & 63) == 63) ? 0 : ((p + 1) & 255);
  endfunction

  task automatic clkBit(input logic hostBit, input logic drv);
    sdaHost = hostBit;
    repeat (10) @(posedge clk);
    expOe = drv;
    scl = 1'b1;
    repeat (3) @(posedge clk);
    chkOn = 1'b1;
    repeat (7) @(posedge clk);
    lastBit = sdaLine;
    repeat (10) @(posedge clk);
    chkOn = 1'b0;
    scl = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  task automatic startCond();
    sdaHost = 1'b1;
    repeat (10) @(posedge clk);
    scl = 1'b1;
    repeat (10) @(posedge clk);
    sdaHost = 1'b0;
    repeat (20) @(posedge clk);
    scl = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  task automatic stopCond();
    sdaHost = 1'b0;
    repeat (10) @(posedge clk);
    scl = 1'b1;
    repeat (10) @(posedge clk);
    sdaHost = 1'b1;
    repeat (20) @(posedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck);
    for (int i = 7; i >= 0; i--) clkBit(b[i], 1'b0);
    clkBit(1'b1, expAck);
  endtask

  task automatic recvByte(input logic [7:0] exp, input bit hostAck, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, ~exp[i]);
      got[i] = lastBit;
    end
    clkBit(hostAck ? 1'b0 : 1'b1, 1'b0);
    check(got == exp, req, got, exp);
  endtask

  task automatic wrRegs(input int p, input int n, input logic [7:0] d0, input logic [7:0] d1);
    startCond();
    sendByte({MY_ADDR, 1'b0}, 1'b1);
    sendByte(p[7:0], 1'b1);
    ptrM = p;
    for (int k = 0; k < n; k++) begin
      sendByte(k == 0 ? d0 : d1, 1'b1);
      regsM[ptrM & 63] = (k == 0) ? int'(d0) : int'(d1);
      ptrM = nextPtr(ptrM);
    end
    stopCond();
  endtask

  task automatic rdRegs(input int n, input string req);
    startCond();
    sendByte({MY_ADDR, 1'b1}, 1'b1);
    for (int k = 0; k < n; k++) begin
      recvByte(regsM[ptrM & 63][7:0], k < n - 1, req);
      if (k < n - 1) ptrM = nextPtr(ptrM);
    end
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) regsM[i] = 0;
    repeat (5) @(posedge clk);
    #1;
    check(sdaOe == 1'b0, "R1", sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    check(sdaOe == 1'b0, "R1", sdaOe, 0);
    scl = 1'b0;
    repeat (10) @(posedge clk);

    curReq = "R1"; rdRegs(1, "R1");                      // pointer 0, reg 0 cleared
    curReq = "R2"; wrRegs(5, 1, 8'hA5, 8'h00);           // R2 ack, R4 store
    curReq = "R3"; wrRegs(5, 0, 8'h00, 8'h00);           // pointer only
    curReq = "R5"; rdRegs(1, "R5");                      // A5 MSB first
    curReq = "R6"; rdRegs(1, "R6");                      // same register again
    curReq = "R4"; wrRegs(9, 1, 8'h3C, 8'h00);
    curReq = "R6"; rdRegs(1, "R6");                      // pointer now 10 -> 0

    curReq = "R7";                                       // foreign addresses
    startCond();
    sendByte({4'b1011, STRAP, 1'b0}, 1'b0);
    sendByte(8'h05, 1'b0);
    sendByte(8'hFF, 1'b0);
    stopCond();
    startCond();
    sendByte({4'b1001, 3'b001, 1'b0}, 1'b0);
    sendByte(8'h05, 1'b0);
    stopCond();
    wrRegs(5, 0, 8'h00, 8'h00);
    rdRegs(1, "R7");                                     // still A5

    curReq = "R8"; wrRegs(8'h3F, 2, 8'h11, 8'h22);      // wrap on write
    check(ptrM == 1, "R8", ptrM, 1);
    wrRegs(8'h3E, 0, 8'h00, 8'h00);
    curReq = "R8"; rdRegs(3, "R8");                      // 3E, 3F, 00 via host ACK
    rdRegs(1, "R8");                                     // NACKed last, stays at 00

    curReq = "R9"; wrRegs(8'h45, 1, 8'h5A, 8'h00);
    wrRegs(8'h05, 0, 8'h00, 8'h00);
    curReq = "R9"; rdRegs(1, "R9");                      // reg 5 now 5A
    wrRegs(8'hC6, 0, 8'h00, 8'h00);
    rdRegs(1, "R9");                                     // upper bits ignored

    curReq = "R10";                                      // aborted address byte
    startCond();
    for (int i = 0; i < 4; i++) clkBit(MY_ADDR[6 - i], 1'b0);
    stopCond();
    wrRegs(8'h20, 1, 8'h77, 8'h00);
    curReq = "R10";
    startCond();                                         // write pointer, repeated start, read
    sendByte({MY_ADDR, 1'b0}, 1'b1);
    sendByte(8'h20, 1'b1);
    ptrM = 8'h20;
    startCond();
    sendByte({MY_ADDR, 1'b1}, 1'b1);
    recvByte(8'h77, 1'b0, "R10");
    clkBit(1'b1, 1'b0);                                  // released after NACK
    stopCond();
    check(sdaOe == 1'b0, "R10", sdaOe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule